// File: doc/BRIEF.md
# Gated Clock Divider and Stop Controller

This block turns one fast source clock into three groups of divided clock outputs and parks each group low on request. A group of six outputs runs at the source rate divided by `DIV_SLOW` (a 33 MHz class rate from a 133 MHz class source). A second group of three outputs runs either at that slow rate or at the source rate divided by `DIV_FAST` (66 MHz class), chosen by a select input. One more slow-rate output never stops. Two active-low stop requests, each passed through a synchronizer, halt the groups. The request that governs the selectable group depends on the rate that group runs at.

All outputs of one rate share one divider counter, so they stay phase-aligned. A group may change between running and stopped only at a period boundary. It therefore stops after a complete low phase and restarts with a full high phase. The block also captures four power-on strap inputs (three frequency-select bits and a spread-enable bit) on the first source clock edge after reset is released, and shows them on a status output.

Top module: `clkgrp_gate_top`

## Requirements
- R1: While `rst_n` is low, every clock output is low and `strap_status` and `strap_valid` are 0.
- R2: After reset release, all six `clk_main` bits are identical and have period `DIV_SLOW` with `DIV_SLOW/2` high cycles. The first output edge after release is a high phase that starts on the first source edge.
- R3: `clk_free` has the same waveform and phase as an unstopped `clk_main`, whatever `stop_a_n` and `stop_b_n` do.
- R4: `sel_slow` = 1 gives `clk_sel` period `DIV_SLOW`. `sel_slow` = 0 gives period `DIV_FAST` with `DIV_FAST/2` high cycles. Both are aligned to reset release, and all three bits are identical.
- R5: `stop_a_n` low halts `clk_main`, and also halts `clk_sel` when `sel_slow` = 1. `stop_b_n` has no effect on these outputs.
- R6: When `sel_slow` = 0, `stop_b_n` low halts `clk_sel` and `stop_a_n` has no effect on it.
- R7: A stop input sampled at source edge n (edges counted from 1 after release) decides whether the output of rate divisor D runs during the period that begins after edge n+2, if that edge is a multiple of D. A halted output is therefore low at most D+2 edges after the request, and there is never a shortened high phase.
- R8: `strap_status` = {`strap_spread`, `strap_fs[2:0]`} (spread in bit 3) holds the values present at the first edge after release. `strap_valid` rises at that edge. Later changes to the strap inputs are ignored until the next reset.
- R9: `sel_slow` is sampled only while `rst_n` is low. Changing it during operation does not change the `clk_sel` rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stop_a_n | input | 1 | Active-low stop for slow-rate outputs (asynchronous) |
| stop_b_n | input | 1 | Active-low stop for the selectable group at the fast rate (asynchronous) |
| sel_slow | input | 1 | Selectable group rate: 1 slow, 0 fast; sampled during reset |
| strap_fs | input | 3 | Frequency-select power-on straps |
| strap_spread | input | 1 | Spread-enable power-on strap |
| clk_main | output | 6 | Stoppable slow-rate group |
| clk_sel | output | 3 | Selectable-rate group |
| clk_free | output | 1 | Free-running slow-rate output |
| strap_status | output | 4 | Captured straps {spread, fs[2:0]} |
| strap_valid | output | 1 | Straps have been captured |

## Verification
The bench sweeps every combination of stop-pulse length and gap from 1 to 9 cycles, in both rate settings of the selectable group. This lands stop edges on every phase of each divider. A design that gates the output without waiting for a period boundary would emit a truncated high pulse, or would restart part-way through a high phase. An off-by-one in the synchronizer delay would shift the period in which the stop takes effect. Both show up against the arithmetic model. With `stop_b_n` toggled independently, the bench exposes a stop routed to the wrong group, for example a free output that stops or a fast group that obeys `stop_a_n`. Changing the straps and `sel_slow` after release catches a design that keeps sampling them.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;
  typedef struct packed {
    logic       spread;
    logic [2:0] fs;
  } strap_t;
endpackage

// File: rtl/clkgrp_divcnt.sv
module clkgrp_divcnt #(
  parameter int DIV = 4,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2 / R4: the shared phase counter wraps to zero after its last value
  assert_cnt_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/clkgrp_sync.sv
module clkgrp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], async_i};

  // reset value 1: request inactive (run)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkgrp_gate.sv
module clkgrp_gate #(
  parameter int DIV = 4,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          run_req_i,
  output logic          clk_o
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);
  localparam int            AW   = $clog2(DIV + 3);
  localparam logic [AW-1:0] AMAX = AW'(DIV + 2);

  logic run_q, run_d;
  logic out_q, out_d;
  logic period_end;

  assign period_end = (cnt_i == LAST);

  always_comb begin
    run_d = run_q;
    if (period_end) run_d = run_req_i;
    out_d = (cnt_i < HALF) && run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;

  // checker state: edges for which the request has been low
  logic [AW-1:0] age_q, age_d;
  always_comb begin
    age_d = age_q;
    if (run_req_i)         age_d = '0;
    else if (age_q != AMAX) age_d = age_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  // R7: a high phase only begins at the start of a divider period
  assert_rise_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(cnt_i) == '0));
  // R7: a high phase only ends after its full width
  assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> ($past(cnt_i) == HALF));
  // R7: a held request parks the output low within DIV+2 edges
  assert_stop_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AMAX) |-> !out_q);
endmodule

// File: rtl/clkgrp_strap.sv
module clkgrp_strap
  import clkgrp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t strap_i,
  input  logic   sel_i,
  output strap_t strap_o,
  output logic   valid_o,
  output logic   sel_o
);
  strap_t strap_q, strap_d;
  logic   valid_q, valid_d;
  logic   sel_q;

  always_comb begin
    strap_d = strap_q;
    valid_d = valid_q;
    if (!valid_q) begin
      strap_d = strap_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      valid_q <= 1'b0;
    end else begin
      strap_q <= strap_d;
      valid_q <= valid_d;
    end
  end

  // rate select: loaded only on edges while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= sel_i;
  end

  assign strap_o = strap_q;
  assign valid_o = valid_q;
  assign sel_o   = sel_q;

  // R8: captured straps never change once valid
  assert_strap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> $stable(strap_q));
  // R9: rate select frozen during operation
  assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n || !valid_q)
    $stable(sel_q));
endmodule

// File: rtl/clkgrp_gate_top.sv
module clkgrp_gate_top
  import clkgrp_pkg::*;
#(
  parameter int DIV_SLOW    = 4,
  parameter int DIV_FAST    = 2,
  parameter int N_MAIN      = 6,
  parameter int N_SEL       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              stop_a_n,
  input  logic              stop_b_n,
  input  logic              sel_slow,
  input  logic [2:0]        strap_fs,
  input  logic              strap_spread,
  output logic [N_MAIN-1:0] clk_main,
  output logic [N_SEL-1:0]  clk_sel,
  output logic              clk_free,
  output logic [3:0]        strap_status,
  output logic              strap_valid
);
  localparam int CWS = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam int CWF = (DIV_FAST > 2) ? $clog2(DIV_FAST) : 1;

  // synchronized stop requests, index 0 = a, 1 = b (1 = run)
  logic [1:0] stop_raw;
  logic [1:0] run_req;
  assign stop_raw = {stop_b_n, stop_a_n};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    clkgrp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_src), .rst_n(rst_n), .async_i(stop_raw[g]), .sync_o(run_req[g]));
  end

  logic [CWS-1:0] cnt_slow;
  logic [CWF-1:0] cnt_fast;

  clkgrp_divcnt #(.DIV(DIV_SLOW), .CW(CWS)) u_cnt_slow (
    .clk(clk_src), .rst_n(rst_n), .cnt_o(cnt_slow));
  clkgrp_divcnt #(.DIV(DIV_FAST), .CW(CWF)) u_cnt_fast (
    .clk(clk_src), .rst_n(rst_n), .cnt_o(cnt_fast));

  strap_t strap_in, strap_q;
  logic   sel_q;
  assign strap_in = '{spread: strap_spread, fs: strap_fs};

  clkgrp_strap u_strap (
    .clk(clk_src), .rst_n(rst_n), .strap_i(strap_in), .sel_i(sel_slow),
    .strap_o(strap_q), .valid_o(strap_valid), .sel_o(sel_q));
  assign strap_status = strap_q;

  logic g_main, g_free, g_sel_slow, g_sel_fast, g_sel;

  clkgrp_gate #(.DIV(DIV_SLOW), .CW(CWS)) u_gate_main (
    .clk(clk_src), .rst_n(rst_n), .cnt_i(cnt_slow), .run_req_i(run_req[0]), .clk_o(g_main));
  clkgrp_gate #(.DIV(DIV_SLOW), .CW(CWS)) u_gate_free (
    .clk(clk_src), .rst_n(rst_n), .cnt_i(cnt_slow), .run_req_i(1'b1), .clk_o(g_free));
  clkgrp_gate #(.DIV(DIV_SLOW), .CW(CWS)) u_gate_sel_slow (
    .clk(clk_src), .rst_n(rst_n), .cnt_i(cnt_slow), .run_req_i(run_req[0]), .clk_o(g_sel_slow));
  clkgrp_gate #(.DIV(DIV_FAST), .CW(CWF)) u_gate_sel_fast (
    .clk(clk_src), .rst_n(rst_n), .cnt_i(cnt_fast), .run_req_i(run_req[1]), .clk_o(g_sel_fast));

  // select is static after reset, so this mux cannot glitch
  assign g_sel = sel_q ? g_sel_slow : g_sel_fast;

  for (genvar i = 0; i < N_MAIN; i++) begin : g_main_fan
    assign clk_main[i] = g_main;
  end
  for (genvar i = 0; i < N_SEL; i++) begin : g_sel_fan
    assign clk_sel[i] = g_sel;
  end
  assign clk_free = g_free;

  // R3: the free output goes high at every slow period start
  assert_free_runs_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
    (cnt_slow == '0) |=> clk_free);
  // R1: nothing toggles while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk_src)
    !rst_n |-> (!clk_free && !g_main && !g_sel));
endmodule

// File: tb/clkgrp_gate_top_bench.sv
module clkgrp_gate_top_bench;
  localparam int DS = 4;
  localparam int DF = 2;

  logic clk = 1'b0;
  logic rst_n, stop_a_n, stop_b_n, sel_slow, strap_spread;
  logic [2:0] strap_fs;
  logic [5:0] clk_main;
  logic [2:0] clk_sel;
  logic clk_free, strap_valid;
  logic [3:0] strap_status;

  clkgrp_gate_top #(.DIV_SLOW(DS), .DIV_FAST(DF)) u_clkgrp_gate_top (
    .clk_src(clk), .rst_n(rst_n), .stop_a_n(stop_a_n), .stop_b_n(stop_b_n),
    .sel_slow(sel_slow), .strap_fs(strap_fs), .strap_spread(strap_spread),
    .clk_main(clk_main), .clk_sel(clk_sel), .clk_free(clk_free),
    .strap_status(strap_status), .strap_valid(strap_valid));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic ha [0:4095];
  logic hb [0:4095];
  logic mon_en = 1'b0;
  logic cfg_sel = 1'b1;

  // edge counter and input history, edges numbered from 1 after release
  always @(posedge clk) begin
    if (!rst_n) k = 0;
    else begin
      k = k + 1;
      if (k < 4096) begin
        ha[k] = stop_a_n;
        hb[k] = stop_b_n;
      end
    end
  end

  function automatic logic hget(input logic which, input int idx);
    if (idx < 1 || idx > 4095) return 1'b1;
    return which ? hb[idx] : ha[idx];
  endfunction

  // expected output after edge n for divisor d with stop source which
  function automatic logic expv(input int n, input int d, input logic which, input logic stoppable);
    int ph, per;
    logic run;
    ph  = (n - 1) % d;
    per = (n - 1) / d;
    run = 1'b1;
    if (stoppable && per > 0) run = hget(which, per * d - 2);
    return (ph < d / 2) && run;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: got %h expected %h", req, k, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && rst_n && k > 0) begin
      logic em, es, ef;
      em = expv(k, DS, 1'b0, 1'b1);
      ef = expv(k, DS, 1'b0, 1'b0);
      if (cfg_sel) es = expv(k, DS, 1'b0, 1'b1);
      else         es = expv(k, DF, 1'b1, 1'b1);
      chk("R2/R5/R7 clk_main", {2'b0, clk_main}, {2'b0, {6{em}}});
      chk("R3 clk_free", {7'b0, clk_free}, {7'b0, ef});
      chk(cfg_sel ? "R4/R5 clk_sel slow" : "R4/R6 clk_sel fast", {5'b0, clk_sel}, {5'b0, {3{es}}});
    end
  end

  task automatic do_reset(input logic sel, input logic [2:0] fs, input logic sp);
    @(negedge clk);
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    stop_a_n = 1'b1;
    stop_b_n = 1'b1;
    sel_slow = sel;
    strap_fs = fs;
    strap_spread = sp;
    cfg_sel  = sel;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 outputs low in reset", {clk_free, clk_sel, clk_main[3:0]}, 8'h00);
      chk("R1 strap status in reset", {3'b0, strap_valid, strap_status}, 8'h00);
    end
    rst_n  = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    chk("R8 strap capture", {3'b0, strap_valid, strap_status}, {3'b0, 1'b1, sp, fs});
    chk("R2 first high phase", {2'b0, clk_main}, 8'h3F);
  endtask

  task automatic sweep();
    int t = 0;
    for (int len = 1; len <= 9; len++) begin
      for (int gap = 1; gap <= 9; gap++) begin
        for (int c = 0; c < len + gap; c++) begin
          stop_a_n = (c >= len);
          stop_b_n = !((t % 7) < 3);
          t++;
          @(negedge clk);
        end
      end
    end
    stop_a_n = 1'b1;
    stop_b_n = 1'b1;
  endtask

  task automatic latency_check();
    // hold a stop long enough that every slow output must be parked
    stop_a_n = 1'b0;
    for (int i = 0; i < DS + 3; i++) @(negedge clk);
    for (int i = 0; i < 2 * DS; i++) begin
      chk("R7 parked low within D+2", {2'b0, clk_main}, 8'h00);
      @(negedge clk);
    end
    stop_a_n = 1'b1;
    for (int i = 0; i < 2 * DS; i++) @(negedge clk);
  endtask

  task automatic late_change(input logic [2:0] fs, input logic sp);
    strap_fs     = ~fs;
    strap_spread = ~sp;
    sel_slow     = ~cfg_sel;
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk("R8 straps held", {4'b0, strap_status}, {4'b0, sp, fs});
    chk("R9 select ignored (via clk_sel model)", {7'b0, strap_valid}, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; stop_a_n = 1'b1; stop_b_n = 1'b1;
    sel_slow = 1'b1; strap_fs = 3'b000; strap_spread = 1'b1;
    // slow selectable group
    do_reset(1'b1, 3'b101, 1'b1);
    sweep();
    latency_check();
    late_change(3'b101, 1'b1);
    // fast selectable group
    do_reset(1'b0, 3'b010, 1'b0);
    sweep();
    latency_check();
    late_change(3'b010, 1'b0);
    mon_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule